// File: doc/BRIEF.md
# Full-Period Zero-Inclusive Fibonacci Sequence Generator

This block is an 8-bit pseudo-random state generator built on a right-shifting Fibonacci feedback register. A plain XOR feedback register cycles through 255 states and can never reach the all-zero pattern. That pattern is a lock-up state: once there, the register stays there. This design adds that pattern to the cycle. It places the zero state between the state that would normally lead to `0x01` and `0x01` itself. The result is a single loop through all 256 values.

Two comparators sit beside the feedback path. The first detects the state whose normal successor is `0x01` and forces the next state to zero. The second detects zero and forces the next state to `0x01`. Every other state takes the normal shift-and-feedback step. The state is a register, so both outputs come straight from flip-flops. A synchronous reset clears the register to zero. The first step after reset is released therefore produces `0x01`. The lowest bit of the state also serves as a one-bit serial stream.

Top module: `zfib_lfsr`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, the state becomes `0x00`. It stays `0x00` for as long as `rst` stays high.
- R2: When the state is `0x00` and `rst` is low, the next state is `0x01`.
- R3: When the state is `0x02`, the next state is `0x00`. `0x02` is the state whose unmodified successor would be `0x01`.
- R4: In every other state S, the next state is {f, S[7:1]}, where f = S[0] ^ S[2] ^ S[3] ^ S[4]. This is the feedback polynomial x^8 + x^6 + x^5 + x^4 + 1.
- R5: Starting from `0x01`, 256 consecutive steps visit each 8-bit value exactly once, and the 257th value equals the first.
- R6: `serial_o` always equals bit 0 of `state_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the state |
| state_o | output | 8 | Registered generator state |
| serial_o | output | 1 | Serial stream, the rightmost state bit |

## Verification
The main stimulus is a free run of two full periods from reset. It is compared value by value against a model built only from the feedback rule and the two forced transitions. This run tells a wrong tap, a wrong shift direction or a misplaced splice apart from a correct design. A per-value visit table, kept over the first 256 values, separates a true 256-state loop from a shorter loop or a sequence that repeats values. A reset applied in the middle of the run shows that a non-zero state is cleared and held at zero. It also shows that the release step again leads into `0x01`.

// File: rtl/zfib_pkg.sv
package zfib_pkg;

  localparam int unsigned ZF_WIDTH = 8;
  localparam logic [ZF_WIDTH-1:0] ZF_TAPS = 8'b0001_1101;

  function automatic logic [ZF_WIDTH-1:0] zf_step(
    input logic [ZF_WIDTH-1:0] s,
    input logic [ZF_WIDTH-1:0] taps
  );
    return {^(s & taps), s[ZF_WIDTH-1:1]};
  endfunction

  // Unique state whose unmodified successor is the given target.
  function automatic logic [ZF_WIDTH-1:0] zf_pred(
    input logic [ZF_WIDTH-1:0] target,
    input logic [ZF_WIDTH-1:0] taps
  );
    logic [ZF_WIDTH-1:0] p;
    p = {target[ZF_WIDTH-2:0], 1'b0};
    p[0] = target[ZF_WIDTH-1] ^ (^(p & taps));
    return p;
  endfunction

endpackage

// File: rtl/zfib_feedback.sv
module zfib_feedback #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'b0001_1101
) (
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH-1:0] tap_bits;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_tap
      if (TAPS[g]) begin : g_on
        assign tap_bits[g] = cur_i[g];
      end else begin : g_off
        assign tap_bits[g] = 1'b0;
      end
    end
  endgenerate

  assign nxt_o = {^tap_bits, cur_i[WIDTH-1:1]};
endmodule

// File: rtl/zfib_splice.sv
module zfib_splice #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] PRED = 8'h02
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] poly_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic hit_pred;
  logic hit_zero;

  assign hit_pred = (cur_i == PRED);
  assign hit_zero = (cur_i == ZERO);

  always_comb begin
    if (hit_pred)      nxt_o = ZERO;
    else if (hit_zero) nxt_o = ONE;
    else               nxt_o = poly_i;
  end
endmodule

// File: rtl/zfib_state_reg.sv
module zfib_state_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/zfib_lfsr.sv
module zfib_lfsr
  import zfib_pkg::*;
#(
  parameter int unsigned WIDTH = ZF_WIDTH,
  parameter logic [WIDTH-1:0] TAPS = ZF_TAPS
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] state_o,
  output logic             serial_o
);
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] PRED = zf_pred(ONE, TAPS);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] poly_nxt;
  logic [WIDTH-1:0] state_nxt;

  zfib_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
    .cur_i (state_q),
    .nxt_o (poly_nxt)
  );

  zfib_splice #(.WIDTH(WIDTH), .PRED(PRED)) u_splice (
    .cur_i  (state_q),
    .poly_i (poly_nxt),
    .nxt_o  (state_nxt)
  );

  zfib_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk (clk),
    .rst (rst),
    .d_i (state_nxt),
    .q_o (state_q)
  );

  assign state_o  = state_q;
  assign serial_o = state_q[0];
endmodule

// File: rtl/zfib_lfsr_chk.sv
module zfib_lfsr_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] state_o,
  input logic             serial_o
);
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] PRED = {ONE[WIDTH-2:0], 1'b0};

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      AST_RESET_ZERO: assert (state_o == '0); // R1
    end
  end

  AST_ZERO_TO_ONE: assert property (@(posedge clk) disable iff (rst)
    state_o == '0 |=> state_o == ONE); // R2

  AST_PRED_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    state_o == PRED |=> state_o == '0); // R3

  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (state_o != '0 && state_o != PRED) |=> state_o[WIDTH-2:0] == $past(state_o[WIDTH-1:1])); // R4

  AST_SERIAL_BIT: assert property (@(posedge clk) disable iff (rst)
    $past(state_o[1]) && state_o != '0 && state_o != ONE |-> serial_o); // R6
endmodule

bind zfib_lfsr zfib_lfsr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .state_o  (state_o),
  .serial_o (serial_o)
);

// File: tb/zfib_lfsr_tb.sv
module zfib_lfsr_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] state_o;
  logic       serial_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] expq[$];
  bit seen [256];
  int idx = 0;
  logic [7:0] first_val = 8'h00;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  zfib_lfsr u_dut (.clk(clk), .rst(rst), .state_o(state_o), .serial_o(serial_o));

  function automatic logic [7:0] model(input logic [7:0] s);
    if (s == 8'h00) return 8'h01;      // R2
    if (s == 8'h02) return 8'h00;      // R3
    return {s[0] ^ s[2] ^ s[3] ^ s[4], s[7:1]}; // R4
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_expected(input int n);
    logic [7:0] v = 8'h01;
    for (int i = 0; i < n; i++) begin
      expq.push_back(v);
      v = model(v);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && expq.size() > 0) begin
      logic [7:0] e;
      e = expq.pop_front();
      chk(state_o == e, "R4 sequence", state_o, e);
      chk(serial_o == state_o[0], "R6 serial", serial_o, state_o[0]);
      if (idx == 0) first_val = state_o;
      if (idx < 256) begin
        chk(!seen[state_o], "R5 unique", state_o, idx);
        seen[state_o] = 1'b1;
      end
      if (idx == 256) chk(state_o == first_val, "R5 repeat", state_o, first_val);
      idx++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(state_o == 8'h00, "R1 reset", state_o, 0);
    chk(serial_o == 1'b0, "R6 reset serial", serial_o, 0);
    drive_expected(512);
    rst = 1'b0;
    @(posedge clk);
    mon_en = 1'b1;
    wait (expq.size() == 0);
    @(negedge clk);
    mon_en = 1'b0;
    for (int k = 0; k < 256; k++) chk(seen[k], "R5 coverage", k, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(state_o == 8'h00, "R1 mid reset", state_o, 0);
    @(negedge clk);
    chk(state_o == 8'h00, "R1 held", state_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(state_o == 8'h01, "R2 release", state_o, 1);
    @(negedge clk);
    chk(state_o == model(8'h01), "R4 after release", state_o, model(8'h01));
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) chk(1'b0, "watchdog", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule